// File: doc/BRIEF.md
# Serial Channel Loopback and Interrupt Mask Unit

This block wraps one existing UART core with an 8-bit extension mode register that the host can only write. The register picks how the core's serial data and handshake lines reach the outside world. They either pass straight through to the pins, or they are folded back onto the core for a self-test. The register can also pin the incoming modem handshakes to their active level. It selects where the core's bit-clock tick comes from, and which status signal drives a shared output pin.

The block also merges the core's four status events into one registered interrupt line. Each event is gated by its own enable bit. On reset the register loads F0h, so all four interrupts are enabled and loopback, override and internal clocking are off. The reset input is asynchronous and active low. Its release is synchronised to the clock through a short flop chain.

Top module: `sce_unit`

## Requirements
- R1: After reset the mode register holds F0h. All four interrupt sources are enabled, loopback and the modem override are off, the external tick is selected and the shared pin shows transmitter-empty.
- R2: Mode bits 7, 6, 5 and 4 enable the transmitter-empty, transmitter-ready, receiver-ready and sync-detect interrupts. A 1 enables the source and a 0 blocks it, so a blocked event leaves `irq` low.
- R3: `irq` is the OR of the enabled events, taken through one register. It changes on the clock edge after the event changes.
- R4: With bit 3 set (loopback), the core's receive data comes from its own transmit data, its CTS comes from its RTS and its DSR comes from its DTR.
- R5: In loopback, `pin_txd`, `pin_rts_n` and `pin_dtr_n` are held at 1, and the pin inputs have no effect on the core.
- R6: With bit 2 set and loopback off, `core_cts_n` and `core_dsr_n` are 0 whatever the pins show.
- R7: With bits 3 and 2 both clear, the core's transmit data, RTS and DTR pass to the pins, and the pins' receive data, CTS and DSR pass to the core.
- R8: With bits 3 and 2 both set, loopback decides CTS and DSR.
- R9: Mode bits 1..0 pick the core tick. Values 00 and 01 take `ext_tick`, and values 10 and 11 take `brg_tick`.
- R10: Mode bit 0 picks the source of `pin_shared`. A 0 selects `core_txempty` and a 1 selects `core_st1`.
- R11: A write with `wr_en` high loads `wr_data` on that clock edge. Without a write the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write value |
| core_txd | input | 1 | Transmit data from the core |
| core_rts_n | input | 1 | RTS from the core, active low |
| core_dtr_n | input | 1 | DTR from the core, active low |
| core_rxd | output | 1 | Receive data to the core |
| core_cts_n | output | 1 | CTS to the core, active low |
| core_dsr_n | output | 1 | DSR to the core, active low |
| pin_txd | output | 1 | Transmit data pin |
| pin_rts_n | output | 1 | RTS pin |
| pin_dtr_n | output | 1 | DTR pin |
| pin_rxd | input | 1 | Receive data pin |
| pin_cts_n | input | 1 | CTS pin |
| pin_dsr_n | input | 1 | DSR pin |
| ext_tick | input | 1 | External bit-clock tick |
| brg_tick | input | 1 | Baud generator tick |
| core_tick | output | 1 | Selected tick to the core |
| core_txempty | input | 1 | Transmitter-empty status from the core |
| core_st1 | input | 1 | Alternate status output from the core |
| pin_shared | output | 1 | Shared status pin |
| ev_txempty | input | 1 | Transmitter-empty event |
| ev_txrdy | input | 1 | Transmitter-ready event |
| ev_rxrdy | input | 1 | Receiver-ready event |
| ev_syndet | input | 1 | Sync-detect event |
| irq | output | 1 | Merged interrupt |

## Verification
The assertions assume that `wr_data`, the events and the pin inputs are stable and known at each rising edge. They also assume that `rst_n` is released only after the inputs have settled. The bench keeps to this by changing every input on the falling edge. It samples outputs a nanosecond after a falling edge, so each write or event change has passed exactly one rising edge before the next check.

// File: rtl/sce_pkg.sv
package sce_pkg;
  localparam int unsigned MODE_W   = 8;
  localparam int unsigned NUM_EV   = 4;
  localparam logic [MODE_W-1:0] MODE_RST = 8'hF0;

  typedef struct packed {
    logic [NUM_EV-1:0] irq_en;    // [3]=txempty [2]=txrdy [1]=rxrdy [0]=syndet
    logic              loop_en;
    logic              mdm_force;
    logic [1:0]        clk_src;
  } mode_t;
endpackage

// File: rtl/sce_rst_sync.sv
module sce_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/sce_mode_reg.sv
module sce_mode_reg
  import sce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output mode_t             mode
);
  mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) mode_d = mode_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= mode_t'(MODE_RST);
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mode == mode_t'($past(wr_data)))); // R11
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode)); // R11
endmodule

// File: rtl/sce_line_router.sv
module sce_line_router
  import sce_pkg::*;
(
  input  mode_t mode,
  input  logic  core_txd,
  input  logic  core_rts_n,
  input  logic  core_dtr_n,
  output logic  core_rxd,
  output logic  core_cts_n,
  output logic  core_dsr_n,
  output logic  pin_txd,
  output logic  pin_rts_n,
  output logic  pin_dtr_n,
  input  logic  pin_rxd,
  input  logic  pin_cts_n,
  input  logic  pin_dsr_n,
  input  logic  ext_tick,
  input  logic  brg_tick,
  output logic  core_tick,
  input  logic  core_txempty,
  input  logic  core_st1,
  output logic  pin_shared
);
  always_comb begin
    if (mode.loop_en) begin
      core_rxd   = core_txd;
      core_cts_n = core_rts_n;
      core_dsr_n = core_dtr_n;
      pin_txd    = 1'b1;
      pin_rts_n  = 1'b1;
      pin_dtr_n  = 1'b1;
    end else begin
      core_rxd   = pin_rxd;
      core_cts_n = mode.mdm_force ? 1'b0 : pin_cts_n;
      core_dsr_n = mode.mdm_force ? 1'b0 : pin_dsr_n;
      pin_txd    = core_txd;
      pin_rts_n  = core_rts_n;
      pin_dtr_n  = core_dtr_n;
    end
  end

  always_comb core_tick  = mode.clk_src[1] ? brg_tick : ext_tick;
  always_comb pin_shared = mode.clk_src[0] ? core_st1 : core_txempty;
endmodule

// File: rtl/sce_irq_merge.sv
module sce_irq_merge
  import sce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] events,
  input  logic [NUM_EV-1:0] enables,
  output logic              irq
);
  logic [NUM_EV-1:0] gated;
  logic irq_q, irq_d;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_gate
    assign gated[g] = events[g] & enables[g];
  end

  always_comb irq_d = |gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ((events & enables) != '0) |=> irq); // R3
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((events & enables) == '0) |=> !irq); // R2
endmodule

// File: rtl/sce_unit.sv
module sce_unit
  import sce_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       core_txd,
  input  logic       core_rts_n,
  input  logic       core_dtr_n,
  output logic       core_rxd,
  output logic       core_cts_n,
  output logic       core_dsr_n,
  output logic       pin_txd,
  output logic       pin_rts_n,
  output logic       pin_dtr_n,
  input  logic       pin_rxd,
  input  logic       pin_cts_n,
  input  logic       pin_dsr_n,
  input  logic       ext_tick,
  input  logic       brg_tick,
  output logic       core_tick,
  input  logic       core_txempty,
  input  logic       core_st1,
  output logic       pin_shared,
  input  logic       ev_txempty,
  input  logic       ev_txrdy,
  input  logic       ev_rxrdy,
  input  logic       ev_syndet,
  output logic       irq
);
  logic  rst_q_n;
  mode_t mode;
  logic [NUM_EV-1:0] ev_vec;

  assign ev_vec = {ev_txempty, ev_txrdy, ev_rxrdy, ev_syndet};

  sce_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  sce_mode_reg u_mode (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_data(wr_data), .mode(mode));

  sce_line_router u_route (
    .mode(mode), .core_txd(core_txd), .core_rts_n(core_rts_n), .core_dtr_n(core_dtr_n),
    .core_rxd(core_rxd), .core_cts_n(core_cts_n), .core_dsr_n(core_dsr_n),
    .pin_txd(pin_txd), .pin_rts_n(pin_rts_n), .pin_dtr_n(pin_dtr_n),
    .pin_rxd(pin_rxd), .pin_cts_n(pin_cts_n), .pin_dsr_n(pin_dsr_n),
    .ext_tick(ext_tick), .brg_tick(brg_tick), .core_tick(core_tick),
    .core_txempty(core_txempty), .core_st1(core_st1), .pin_shared(pin_shared));

  sce_irq_merge u_irq (
    .clk(clk), .rst_n(rst_q_n), .events(ev_vec), .enables(mode.irq_en), .irq(irq));

  AST_LOOP_DATA: assert property (@(posedge clk) disable iff (!rst_q_n)
    mode.loop_en |-> (core_rxd == core_txd && core_cts_n == core_rts_n
                      && core_dsr_n == core_dtr_n)); // R4
  AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    mode.loop_en |-> (pin_txd && pin_rts_n && pin_dtr_n)); // R5
  AST_FORCE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!mode.loop_en && mode.mdm_force) |-> (!core_cts_n && !core_dsr_n)); // R6
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!mode.loop_en && !mode.mdm_force) |-> (pin_txd == core_txd && core_rxd == pin_rxd
                                            && core_cts_n == pin_cts_n)); // R7
  AST_TICK_SELECT: assert property (@(posedge clk) disable iff (!rst_q_n)
    core_tick == (mode.clk_src[1] ? brg_tick : ext_tick)); // R9
endmodule

// File: tb/sim_sce_unit.sv
`timescale 1ns/1ps
module sim_sce_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic core_txd = 1'b1, core_rts_n = 1'b1, core_dtr_n = 1'b1;
  logic pin_rxd = 1'b1, pin_cts_n = 1'b1, pin_dsr_n = 1'b1;
  logic ext_tick = 1'b0, brg_tick = 1'b0;
  logic core_txempty = 1'b0, core_st1 = 1'b0;
  logic ev_txempty = 1'b0, ev_txrdy = 1'b0, ev_rxrdy = 1'b0, ev_syndet = 1'b0;
  logic core_rxd, core_cts_n, core_dsr_n, pin_txd, pin_rts_n, pin_dtr_n;
  logic core_tick, pin_shared, irq;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  sce_unit u0 (.*);

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b want %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic sample();
    #1;
  endtask

  task automatic write_mode(input logic [7:0] v);
    step(); wr_en = 1'b1; wr_data = v;
    step(); wr_en = 1'b0; wr_data = 8'h00;
    sample();
  endtask

  task automatic set_events(input logic [3:0] e);
    {ev_txempty, ev_txrdy, ev_rxrdy, ev_syndet} = e;
  endtask

  task automatic t_reset();
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    sample();
    check("R1 irq idle", irq, 1'b0);
    pin_rxd = 1'b0; core_txd = 1'b0; pin_cts_n = 1'b0; sample();
    check("R1 no loopback rxd", core_rxd, 1'b0);
    check("R1 no loopback txd", pin_txd, 1'b0);
    check("R1 no override cts", core_cts_n, 1'b0);
    pin_cts_n = 1'b1; sample();
    check("R1 no override cts high", core_cts_n, 1'b1);
    ext_tick = 1'b1; brg_tick = 1'b0; sample();
    check("R1 external tick", core_tick, 1'b1);
    core_txempty = 1'b1; core_st1 = 1'b0; sample();
    check("R1 shared txempty", pin_shared, 1'b1);
    pin_rxd = 1'b1; core_txd = 1'b1; ext_tick = 1'b0;
  endtask

  task automatic t_masks();
    for (int i = 0; i < 4; i++) begin
      step(); set_events(4'b0001 << i); sample();
      check("R3 irq not yet", irq, 1'b0);
      step(); sample();
      check("R1 R2 enabled event raises irq", irq, 1'b1);
      step(); set_events(4'b0000);
      step(); sample();
      check("R3 irq drops", irq, 1'b0);
    end
    // clear one enable at a time: bit 7-i blocks event 3-i
    for (int i = 0; i < 4; i++) begin
      write_mode(8'hF0 & ~(8'h80 >> i));
      step(); set_events(4'b1000 >> i);
      step(); sample();
      check("R2 blocked event", irq, 1'b0);
      step(); set_events(4'b1111);
      step(); sample();
      check("R2 other events pass", irq, 1'b1);
      step(); set_events(4'b0000); step();
    end
    write_mode(8'h00);
    step(); set_events(4'b1111); step(); sample();
    check("R2 all blocked", irq, 1'b0);
    step(); set_events(4'b0000);
    write_mode(8'hF0);
  endtask

  task automatic t_loopback();
    write_mode(8'h08);
    for (int v = 0; v < 2; v++) begin
      core_txd = v[0]; core_rts_n = ~v[0]; core_dtr_n = v[0];
      pin_rxd = ~v[0]; pin_cts_n = v[0]; pin_dsr_n = ~v[0]; sample();
      check("R4 rxd from txd", core_rxd, v[0]);
      check("R4 cts from rts", core_cts_n, ~v[0]);
      check("R4 dsr from dtr", core_dsr_n, v[0]);
      check("R5 txd pin mark", pin_txd, 1'b1);
      check("R5 rts pin idle", pin_rts_n, 1'b1);
      check("R5 dtr pin idle", pin_dtr_n, 1'b1);
    end
  endtask

  task automatic t_override();
    write_mode(8'h04);
    pin_cts_n = 1'b1; pin_dsr_n = 1'b1; pin_rxd = 1'b0; sample();
    check("R6 cts forced", core_cts_n, 1'b0);
    check("R6 dsr forced", core_dsr_n, 1'b0);
    check("R6 rxd still from pin", core_rxd, 1'b0);
    write_mode(8'h00);
    pin_cts_n = 1'b1; pin_dsr_n = 1'b0; core_rts_n = 1'b0; core_dtr_n = 1'b1; core_txd = 1'b0;
    sample();
    check("R7 cts from pin", core_cts_n, 1'b1);
    check("R7 dsr from pin", core_dsr_n, 1'b0);
    check("R7 rts to pin", pin_rts_n, 1'b0);
    check("R7 dtr to pin", pin_dtr_n, 1'b1);
    check("R7 txd to pin", pin_txd, 1'b0);
    write_mode(8'h0C);
    core_rts_n = 1'b1; core_dtr_n = 1'b1; sample();
    check("R8 loopback beats override cts", core_cts_n, 1'b1);
    check("R8 loopback beats override dsr", core_dsr_n, 1'b1);
  endtask

  task automatic t_clock_shared();
    for (int s = 0; s < 4; s++) begin
      write_mode(8'h00 | s[7:0]);
      ext_tick = 1'b1; brg_tick = 1'b0; core_txempty = 1'b1; core_st1 = 1'b0; sample();
      check("R9 tick select", core_tick, (s >= 2) ? 1'b0 : 1'b1);
      check("R10 shared select", pin_shared, s[0] ? 1'b0 : 1'b1);
      ext_tick = 1'b0; brg_tick = 1'b1; core_txempty = 1'b0; core_st1 = 1'b1; sample();
      check("R9 tick select inv", core_tick, (s >= 2) ? 1'b1 : 1'b0);
      check("R10 shared select inv", pin_shared, s[0] ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_hold();
    write_mode(8'h08);
    step(); wr_data = 8'h00; step(); step(); sample();
    core_txd = 1'b0; sample();
    check("R11 no write keeps loopback", pin_txd, 1'b1);
    write_mode(8'h00); sample();
    check("R11 write takes effect", pin_txd, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_masks();
        t_loopback();
        t_override();
        t_clock_shared();
        t_hold();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout want completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule